// File: doc/BRIEF.md
# Priority interrupt presenter

This block sits in front of one processor and decides which interrupt that processor sees. It keeps the processor's current priority threshold, the priority of a software-requested inter-processor interrupt, the priority and source number of the interrupt now pending, and a flag that remembers a refused delivery. Numerically lower priority values are more favoured. 8'hFF is the least favoured value. The inter-processor interrupt uses source number 2.

Interrupt sources offer deliveries as a source number and a priority. The block accepts an offer only when it beats everything the processor currently holds. An accepted offer displaces the interrupt already pending, and that interrupt goes back to the sources for another attempt. A refused offer sets the flag. When the processor later relaxes its threshold or its inter-processor priority, the flag becomes a one-cycle resend request to the sources.

The processor drives four operations: accept the pending interrupt, end of interrupt, set the threshold, and set the inter-processor priority. All results appear one clock after the request. The interrupt line is registered and follows the held state.

Top module: `prio_presenter`

## Requirements
- R1: Synchronous active-high reset sets threshold 8'h00, inter-processor priority 8'hFF, pending priority 8'hFF, pending source 0 and clears the refusal flag. All outputs are low while reset is held and in the first cycle after it.
- R2: A delivery (`dlv_valid`, `dlv_prio`, `dlv_src`) succeeds only when `dlv_prio` is strictly below the threshold, the inter-processor priority and the pending priority. On success, `dlv_ok` is high for one cycle on the next clock, and the pending priority and source take the offered values.
- R3: On a successful delivery, the previously pending source is returned on `rej_src` with `rej_valid`, unless that source is 0 or 2. `rej_valid` never reports source 0 or 2 for any operation.
- R4: A refused delivery sets the refusal flag. A delivery presented in the same cycle as a processor operation is always refused: the operation takes effect and the flag is then set.
- R5: Set inter-processor priority (`op_kind` 2'd3, new value in `op_data[7:0]`) stores the value. When the value is below the threshold and not above the pending priority, it displaces the pending source (reported as in R3), and the pending source becomes 2 with the new value as its priority.
- R6: When set inter-processor priority raises the value numerically above the old one, `resend_req` pulses if the refusal flag was set, and the flag clears.
- R7: Set threshold (`op_kind` 2'd2, `op_data[7:0]`) with a numerically larger value loads it and repeats the R5 displacement check against the held inter-processor priority. It then pulses `resend_req` if the flag was set, and clears the flag.
- R8: Set threshold with a value equal to the current threshold changes no state and produces no output pulse.
- R9: Set threshold with a numerically smaller value loads it. If the pending priority is not below the new threshold, it rejects the pending source (reported as in R3), clears the pending source and sets the pending priority to 8'hFF.
- R10: Accept (`op_kind` 2'd0) returns `{threshold, pending source}` on `acc_data` with `acc_valid` (threshold in bits 31:24). It then loads the threshold from the pending priority, clears the pending source and sets the pending priority to 8'hFF.
- R11: End of interrupt (`op_kind` 2'd1) loads the threshold from `op_data[31:24]` through the R7 path, whatever that value is. It pulses `eoi_valid` with `eoi_src` = `op_data[23:0]` unless that source is 2.
- R12: `irq_out` is high exactly when the pending priority is below the threshold, and it changes on the same edge as the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dlv_valid | input | 1 | Delivery offer present |
| dlv_src | input | 24 | Offered source number |
| dlv_prio | input | 8 | Offered priority |
| op_valid | input | 1 | Processor operation present |
| op_kind | input | 2 | 0 accept, 1 end of interrupt, 2 set threshold, 3 set inter-processor priority |
| op_data | input | 32 | Operand of the operation |
| dlv_ok | output | 1 | Delivery accepted (pulse) |
| rej_valid | output | 1 | A source was displaced (pulse) |
| rej_src | output | 24 | Displaced source number |
| resend_req | output | 1 | Sources should retry refused deliveries (pulse) |
| acc_valid | output | 1 | Accept result valid (pulse) |
| acc_data | output | 32 | Threshold and pending source returned by accept |
| eoi_valid | output | 1 | End of interrupt forwarded to sources (pulse) |
| eoi_src | output | 24 | Source named by the end of interrupt |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A wrong threshold or pending priority shows on `irq_out` on the next edge, and on the next delivery's `dlv_ok`. A lost or stale refusal flag stays hidden until the next relaxing operation, when `resend_req` is missing or appears unasked. A wrong pending source surfaces only at the next accept, through `acc_data`, or at the next displacement, through `rej_src`. The stimulus therefore follows each state change with an operation that exposes it within a few cycles.

// File: rtl/pp_pkg.sv
`timescale 1ns/1ps
package pp_pkg;
    localparam int PRIO_W = 8;
    localparam int SRC_W  = 24;
    localparam int WORD_W = PRIO_W + SRC_W;
    localparam int IPI_DEFAULT = 2;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [SRC_W-1:0]  src_t;

    localparam prio_t PRIO_LEAST = '1;

    typedef enum logic [1:0] {
        OP_ACCEPT = 2'd0,
        OP_EOI    = 2'd1,
        OP_CPPR   = 2'd2,
        OP_MFRR   = 2'd3
    } op_kind_e;

    typedef struct packed {
        prio_t cppr;
        prio_t mfrr;
        prio_t pend;
        src_t  xisr;
        logic  need_resend;
    } pres_state_t;

    typedef struct packed {
        logic              dlv_ok;
        logic              rej_valid;
        src_t              rej_src;
        logic              resend;
        logic              acc_valid;
        logic [WORD_W-1:0] acc_data;
        logic              eoi_valid;
        src_t              eoi_src;
    } pres_event_t;

    localparam pres_state_t STATE_RESET = '{
        cppr: '0, mfrr: PRIO_LEAST, pend: PRIO_LEAST, xisr: '0, need_resend: 1'b0};

    // a displaced source goes back to the sources only if it is a real one
    function automatic logic reportable(input src_t s, input src_t ipi);
        return (s != '0) && (s != ipi);
    endfunction
endpackage

// File: rtl/pp_dlv_unit.sv
`timescale 1ns/1ps
module pp_dlv_unit import pp_pkg::*; #(
    parameter int IPI_SRC_ID = IPI_DEFAULT
) (
    input  pres_state_t cur,
    input  src_t        src,
    input  prio_t       prio,
    output pres_state_t nxt,
    output logic        ok,
    output logic        rej_valid,
    output src_t        rej_src
);
    localparam src_t IPI_SRC = src_t'(IPI_SRC_ID);

    always_comb begin
        nxt       = cur;
        ok        = (prio < cur.cppr) && (prio < cur.mfrr) && (prio < cur.pend);
        rej_valid = 1'b0;
        rej_src   = '0;
        if (ok) begin
            rej_valid = reportable(cur.xisr, IPI_SRC);
            rej_src   = cur.xisr;
            nxt.xisr  = src;
            nxt.pend  = prio;
        end else begin
            nxt.need_resend = 1'b1;
        end
    end
endmodule

// File: rtl/pp_op_unit.sv
`timescale 1ns/1ps
module pp_op_unit import pp_pkg::*; #(
    parameter int IPI_SRC_ID = IPI_DEFAULT
) (
    input  pres_state_t       cur,
    input  op_kind_e          kind,
    input  logic [WORD_W-1:0] data,
    output pres_state_t       nxt,
    output pres_event_t       ev
);
    localparam src_t IPI_SRC = src_t'(IPI_SRC_ID);

    prio_t new_p;
    prio_t top_p;
    prio_t low_p;
    logic  lower;

    assign new_p = data[PRIO_W-1:0];
    assign top_p = data[WORD_W-1 -: PRIO_W];

    always_comb begin
        nxt   = cur;
        ev    = '0;
        lower = 1'b0;
        low_p = top_p;
        case (kind)
            OP_ACCEPT: begin
                ev.acc_valid = 1'b1;
                ev.acc_data  = {cur.cppr, cur.xisr};
                nxt.xisr     = '0;
                nxt.cppr     = cur.pend;
                nxt.pend     = PRIO_LEAST;
            end
            OP_EOI: begin
                lower        = 1'b1;
                low_p        = top_p;
                ev.eoi_valid = (data[SRC_W-1:0] != IPI_SRC);
                ev.eoi_src   = data[SRC_W-1:0];
            end
            OP_CPPR: begin
                if (new_p > cur.cppr) begin
                    lower = 1'b1;
                    low_p = new_p;
                end else if (new_p < cur.cppr) begin
                    nxt.cppr = new_p;
                    if (cur.pend >= new_p) begin
                        ev.rej_valid = reportable(cur.xisr, IPI_SRC);
                        ev.rej_src   = cur.xisr;
                        nxt.xisr     = '0;
                        nxt.pend     = PRIO_LEAST;
                    end
                end
            end
            OP_MFRR: begin
                nxt.mfrr = new_p;
                if ((new_p < cur.cppr) && (new_p <= cur.pend)) begin
                    ev.rej_valid = reportable(cur.xisr, IPI_SRC);
                    ev.rej_src   = cur.xisr;
                    nxt.xisr     = IPI_SRC;
                    nxt.pend     = new_p;
                end
                if (new_p > cur.mfrr) begin
                    ev.resend       = cur.need_resend;
                    nxt.need_resend = 1'b0;
                end
            end
            default: ;
        endcase

        // shared threshold-relaxing path: reload, recheck the IPI, flush resend
        if (lower) begin
            nxt.cppr = low_p;
            if ((cur.mfrr < low_p) && (cur.mfrr <= cur.pend)) begin
                ev.rej_valid = reportable(cur.xisr, IPI_SRC);
                ev.rej_src   = cur.xisr;
                nxt.pend     = cur.mfrr;
                nxt.xisr     = IPI_SRC;
            end
            ev.resend       = cur.need_resend;
            nxt.need_resend = 1'b0;
        end
    end
endmodule

// File: rtl/pp_state_reg.sv
`timescale 1ns/1ps
module pp_state_reg import pp_pkg::*; (
    input  logic        clk,
    input  logic        rst,
    input  pres_state_t nxt,
    input  pres_event_t ev_nxt,
    output pres_state_t st,
    output pres_event_t ev,
    output logic        irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= STATE_RESET;
            ev  <= '0;
            irq <= 1'b0;
        end else begin
            st  <= nxt;
            ev  <= ev_nxt;
            irq <= (nxt.pend < nxt.cppr);
        end
    end
endmodule

// File: rtl/prio_presenter.sv
`timescale 1ns/1ps
module prio_presenter import pp_pkg::*; #(
    parameter int IPI_SRC_ID = IPI_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dlv_valid,
    input  logic [SRC_W-1:0]  dlv_src,
    input  logic [PRIO_W-1:0] dlv_prio,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [WORD_W-1:0] op_data,
    output logic              dlv_ok,
    output logic              rej_valid,
    output logic [SRC_W-1:0]  rej_src,
    output logic              resend_req,
    output logic              acc_valid,
    output logic [WORD_W-1:0] acc_data,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src,
    output logic              irq_out
);
    pres_state_t st_q;
    pres_event_t ev_q;
    pres_state_t dlv_nxt, op_nxt, nxt_sel;
    pres_event_t op_ev, ev_sel;
    logic        dlv_ok_c, dlv_rej_v;
    src_t        dlv_rej_src;

    pp_dlv_unit #(.IPI_SRC_ID(IPI_SRC_ID)) i_dlv (
        .cur(st_q), .src(dlv_src), .prio(dlv_prio), .nxt(dlv_nxt),
        .ok(dlv_ok_c), .rej_valid(dlv_rej_v), .rej_src(dlv_rej_src));

    pp_op_unit #(.IPI_SRC_ID(IPI_SRC_ID)) i_op (
        .cur(st_q), .kind(op_kind_e'(op_kind)), .data(op_data),
        .nxt(op_nxt), .ev(op_ev));

    // processor operations win; a coincident offer is refused
    always_comb begin
        nxt_sel = st_q;
        ev_sel  = '0;
        if (op_valid) begin
            nxt_sel = op_nxt;
            ev_sel  = op_ev;
            if (dlv_valid) nxt_sel.need_resend = 1'b1;
        end else if (dlv_valid) begin
            nxt_sel          = dlv_nxt;
            ev_sel.dlv_ok    = dlv_ok_c;
            ev_sel.rej_valid = dlv_rej_v;
            ev_sel.rej_src   = dlv_rej_src;
        end
    end

    pp_state_reg i_reg (
        .clk(clk), .rst(rst), .nxt(nxt_sel), .ev_nxt(ev_sel),
        .st(st_q), .ev(ev_q), .irq(irq_out));

    assign dlv_ok     = ev_q.dlv_ok;
    assign rej_valid  = ev_q.rej_valid;
    assign rej_src    = ev_q.rej_src;
    assign resend_req = ev_q.resend;
    assign acc_valid  = ev_q.acc_valid;
    assign acc_data   = ev_q.acc_data;
    assign eoi_valid  = ev_q.eoi_valid;
    assign eoi_src    = ev_q.eoi_src;
endmodule

// File: rtl/pp_checker.sv
`timescale 1ns/1ps
module pp_checker import pp_pkg::*; #(
    parameter int IPI_SRC_ID = IPI_DEFAULT
) (
    input logic              clk,
    input logic              rst,
    input logic              dlv_valid,
    input logic [SRC_W-1:0]  dlv_src,
    input logic [PRIO_W-1:0] dlv_prio,
    input logic              op_valid,
    input logic [1:0]        op_kind,
    input logic [WORD_W-1:0] op_data,
    input logic              dlv_ok,
    input logic              rej_valid,
    input logic [SRC_W-1:0]  rej_src,
    input logic              resend_req,
    input logic              acc_valid,
    input logic              irq_out,
    input logic [PRIO_W-1:0] cppr,
    input logic [PRIO_W-1:0] mfrr,
    input logic [PRIO_W-1:0] pend,
    input logic [SRC_W-1:0]  xisr,
    input logic              need_resend
);
    localparam src_t IPI_SRC = src_t'(IPI_SRC_ID);

    AST_DLV_WINS: assert property (@(posedge clk) disable iff (rst)
        dlv_ok |-> ($past(dlv_prio) < $past(cppr)) && ($past(dlv_prio) < $past(mfrr))
                   && ($past(dlv_prio) < $past(pend)) && (pend == $past(dlv_prio))
                   && (xisr == $past(dlv_src))); // R2

    AST_REJ_REAL: assert property (@(posedge clk) disable iff (rst)
        rej_valid |-> (rej_src != '0) && (rej_src != IPI_SRC)); // R3

    AST_FAIL_FLAG: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(dlv_valid) && !dlv_ok) |-> need_resend); // R4

    AST_RESEND_CAUSE: assert property (@(posedge clk) disable iff (rst)
        resend_req |-> $past(need_resend)); // R6

    AST_EQ_NOP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_valid && !dlv_valid && (op_kind == 2'd2)
                              && (op_data[PRIO_W-1:0] == cppr)))
        |-> (cppr == $past(cppr)) && (mfrr == $past(mfrr)) && (pend == $past(pend))
            && (xisr == $past(xisr)) && !rej_valid && !resend_req); // R8

    AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> (xisr == '0) && (cppr == $past(pend)) && (pend == PRIO_LEAST)); // R10

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        irq_out == (pend < cppr)); // R12
endmodule

bind prio_presenter pp_checker #(.IPI_SRC_ID(IPI_SRC_ID)) i_chk (
    .clk(clk), .rst(rst), .dlv_valid(dlv_valid), .dlv_src(dlv_src),
    .dlv_prio(dlv_prio), .op_valid(op_valid), .op_kind(op_kind),
    .op_data(op_data), .dlv_ok(dlv_ok), .rej_valid(rej_valid),
    .rej_src(rej_src), .resend_req(resend_req), .acc_valid(acc_valid),
    .irq_out(irq_out), .cppr(st_q.cppr), .mfrr(st_q.mfrr), .pend(st_q.pend),
    .xisr(st_q.xisr), .need_resend(st_q.need_resend));

// File: tb/test_prio_presenter.sv
`timescale 1ns/1ps
module test_prio_presenter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dlv_valid = 1'b0;
    logic [23:0] dlv_src = '0;
    logic [7:0]  dlv_prio = '0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = '0;
    logic [31:0] op_data = '0;
    logic        dlv_ok, rej_valid, resend_req, acc_valid, eoi_valid, irq_out;
    logic [23:0] rej_src, eoi_src;
    logic [31:0] acc_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prio_presenter i_prio_presenter (
        .clk(clk), .rst(rst), .dlv_valid(dlv_valid), .dlv_src(dlv_src),
        .dlv_prio(dlv_prio), .op_valid(op_valid), .op_kind(op_kind),
        .op_data(op_data), .dlv_ok(dlv_ok), .rej_valid(rej_valid),
        .rej_src(rej_src), .resend_req(resend_req), .acc_valid(acc_valid),
        .acc_data(acc_data), .eoi_valid(eoi_valid), .eoi_src(eoi_src),
        .irq_out(irq_out));

    // flags: {ok, rej, resend, acc, eoi, irq}; val is rej_src, acc_data or eoi_src
    typedef struct packed {
        logic        is_op;
        logic [1:0]  kind;
        logic [31:0] arg;
        logic [5:0]  flags;
        logic [31:0] val;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 32'h05000100, 6'b000000, 32'h0,        4'd4},  // R4 refused at threshold 0
        '{1'b1, 2'd2, 32'h000000FF, 6'b001000, 32'h0,        4'd7},  // R7 relax, resend
        '{1'b0, 2'd0, 32'h05000100, 6'b100001, 32'h0,        4'd2},  // R2 accepted
        '{1'b0, 2'd0, 32'h03000200, 6'b110001, 32'h100,      4'd3},  // R3 displaces 0x100
        '{1'b0, 2'd0, 32'h03000300, 6'b000001, 32'h0,        4'd2},  // R2 equal prio refused
        '{1'b1, 2'd0, 32'h0,        6'b000100, 32'hFF000200, 4'd10}, // R10 accept
        '{1'b0, 2'd0, 32'h02000400, 6'b100001, 32'h0,        4'd2},  // R2
        '{1'b1, 2'd2, 32'h00000002, 6'b010000, 32'h400,      4'd9},  // R9 raise rejects
        '{1'b1, 2'd2, 32'h00000002, 6'b000000, 32'h0,        4'd8},  // R8 equal no-op
        '{1'b1, 2'd3, 32'h00000001, 6'b000001, 32'h0,        4'd5},  // R5 IPI pending
        '{1'b1, 2'd0, 32'h0,        6'b000100, 32'h02000002, 4'd10}, // R10 accept IPI
        '{1'b1, 2'd1, 32'h06000002, 6'b001001, 32'h0,        4'd11}, // R11 IPI eoi, no forward
        '{1'b1, 2'd3, 32'h000000FF, 6'b000001, 32'h0,        4'd6},  // R6 raise, flag clear
        '{1'b1, 2'd0, 32'h0,        6'b000100, 32'h06000002, 4'd10}, // R10
        '{1'b1, 2'd1, 32'hFF000200, 6'b000010, 32'h200,      4'd11}, // R11 forward
        '{1'b0, 2'd0, 32'h07000500, 6'b100001, 32'h0,        4'd2},  // R2
        '{1'b1, 2'd3, 32'h00000004, 6'b010001, 32'h500,      4'd5},  // R5 displaces 0x500
        '{1'b0, 2'd0, 32'h06000600, 6'b000001, 32'h0,        4'd4},  // R4 refused
        '{1'b1, 2'd3, 32'h00000009, 6'b001001, 32'h0,        4'd6},  // R6 resend
        '{1'b1, 2'd2, 32'h00000003, 6'b000000, 32'h0,        4'd9}   // R9 IPI dropped silently
    };

    task automatic drive(input logic dv, input logic [31:0] darg,
                         input logic ov, input logic [1:0] k, input logic [31:0] oarg);
        @(negedge clk);
        dlv_valid = dv;
        dlv_prio  = darg[31:24];
        dlv_src   = darg[23:0];
        op_valid  = ov;
        op_kind   = k;
        op_data   = oarg;
        @(negedge clk);
        dlv_valid = 1'b0;
        op_valid  = 1'b0;
    endtask

    task automatic check(input logic [5:0] ef, input logic [31:0] ev, input string tag);
        logic [5:0] got;
        got = {dlv_ok, rej_valid, resend_req, acc_valid, eoi_valid, irq_out};
        n_chk++;
        if (got !== ef) begin
            n_bad++;
            $display("FAIL %s flags got %b expected %b", tag, got, ef);
        end
        if (ef[4] && rej_src !== ev[23:0]) begin
            n_chk++; n_bad++;
            $display("FAIL %s rej_src got %h expected %h", tag, rej_src, ev[23:0]);
        end
        if (ef[2] && acc_data !== ev) begin
            n_chk++; n_bad++;
            $display("FAIL %s acc_data got %h expected %h", tag, acc_data, ev);
        end
        if (ef[1] && eoi_src !== ev[23:0]) begin
            n_chk++; n_bad++;
            $display("FAIL %s eoi_src got %h expected %h", tag, eoi_src, ev[23:0]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(6'b000000, 32'h0, "R1 reset outputs");

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_op)
                drive(1'b0, 32'h0, 1'b1, VECS[i].kind, VECS[i].arg);
            else
                drive(1'b1, VECS[i].arg, 1'b0, 2'd0, 32'h0);
            check(VECS[i].flags, VECS[i].val, $sformatf("R%0d vec%0d", VECS[i].req, i));
        end

        // R4: op and delivery together; op applies, offer refused (threshold 3 -> FF)
        drive(1'b1, 32'h01000700, 1'b1, 2'd2, 32'h000000FF);
        check(6'b000001, 32'h0, "R4 coincident offer");

        // R1: reset mid-run must clear the refusal flag and pending state
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(6'b000000, 32'h0, "R1 reset held");
        rst = 1'b0;
        drive(1'b0, 32'h0, 1'b1, 2'd2, 32'h000000FF);
        check(6'b000000, 32'h0, "R1 flag cleared by reset");
        drive(1'b1, 32'hFE000800, 1'b0, 2'd0, 32'h0);
        check(6'b100001, 32'h0, "R12 irq after accepted offer");
        drive(1'b0, 32'h0, 1'b1, 2'd0, 32'h0);
        check(6'b000100, 32'hFF000800, "R10 accept after reset");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule